// File: doc/BRIEF.md
# Event Channel Capture Arbiter

This block picks exactly one of eight channel-request lines for each event and keeps the others out until the event sequencer releases it. The request lines are active low. The block synchronises each line into the local clock domain and detects its high-to-low transition. On the first transition it accepts, it latches that channel's flag. The flag stays set, and every other channel stays locked out, until the sequencer raises its clear/busy input.

The outputs are the one-hot flag vector, its binary channel number, and a one-cycle pulse that tells the sequencer an event has been taken. The external enable only matters at the moment a request is captured. Dropping it during an event does not disturb that event. When several lines fall in the same cycle, the lowest-numbered channel wins and the rest are discarded. Because of this, two flags are never set together.

The enable port is meant to be tied or pulled high at integration when nothing drives it. The block treats a high level as enabled.

Top module: `chan_capture_arbiter`

## Requirements
- R1: During and right after reset, the flag vector is all zero, the channel number is 0 and the captured pulse is low.
- R2: Suppose a request line has been high for at least two cycles and is then sampled low. If enable is high, clear is low and no flag is set at that point, that channel's flag bit (bit i for line i) becomes visible after the third rising clock edge, counting from the edge that first samples the line low.
- R3: A line that stays low, or that goes from low to high, never sets a flag. Only a high-to-low transition counts.
- R4: While any flag is set and clear is low, the flag vector holds its value. Transitions on other lines are ignored, and at most one flag bit is ever set.
- R5: With clear high at a rising edge, the flag vector is zero after that edge. Transitions that arrive while clear is high are not remembered afterwards.
- R6: A transition whose capture edge sees enable low sets no flag, and it is not remembered once enable returns high.
- R7: Enable going low after a flag is set leaves the flag and channel number unchanged.
- R8: When several lines produce transitions at the same capture edge, only the lowest-numbered of them is latched.
- R9: The channel number output is the binary index of the set flag bit (0 to 7), and 0 when no flag is set.
- R10: The captured output is high for exactly the one cycle in which the flag vector first becomes nonzero after being zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_n_i | input | 8 | Active-low channel request lines, asynchronous |
| enable_i | input | 1 | External capture enable, high = enabled (tie high if unused) |
| seq_clear_i | input | 1 | Sequencer clear/busy; high clears and inhibits all flags |
| grant_oh_o | output | 8 | One-hot latched channel flags |
| grant_idx_o | output | 3 | Binary index of the latched channel |
| captured_o | output | 1 | One-cycle pulse when an event is captured |

## Verification
A corrupt flag register shows up at the ports in the very cycle it occurs. The symptoms are two bits high in the flag vector, a channel number that disagrees with the set bit, or a flag that changes while the event is still held. A fault in the synchroniser or edge detector shows up one cycle late or early against the three-edge latency. It can also show up as a held-low line being captured as a fresh event. All of these are visible within at most three clock edges of the stimulus, because a reference model is compared on every clock.

// File: rtl/cca_pkg.sv
package cca_pkg;
  localparam int unsigned CCA_CH_DEF   = 8;
  localparam int unsigned CCA_SYNC_DEF = 2;
endpackage

// File: rtl/cca_edge_sync.sv
module cca_edge_sync #(
  parameter int unsigned N_CH        = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] req_n_i,
  output logic [N_CH-1:0] fall_o
);
  logic [N_CH-1:0] stage_q [SYNC_STAGES];
  logic [N_CH-1:0] prev_q;

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '1;
        else if (s == 0) stage_q[s] <= req_n_i;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else prev_q <= stage_q[SYNC_STAGES-1];
  end

  assign fall_o = prev_q & ~stage_q[SYNC_STAGES-1];

  // a detected fall must not persist into the next cycle
  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_o != '0) |=> ((fall_o & $past(fall_o)) == '0)); // R3
endmodule

// File: rtl/cca_lock.sv
module cca_lock #(
  parameter int unsigned N_CH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] fall_i,
  input  logic            enable_i,
  input  logic            seq_clear_i,
  output logic [N_CH-1:0] flags_o,
  output logic            captured_o
);
  function automatic logic [N_CH-1:0] lowest_bit(input logic [N_CH-1:0] v);
    return v & (~v + {{(N_CH-1){1'b0}}, 1'b1});
  endfunction

  logic [N_CH-1:0] flags_q;
  logic            cap_q;
  logic [N_CH-1:0] winner;
  logic            armed;

  assign winner = lowest_bit(fall_i);
  assign armed  = enable_i && !seq_clear_i && (flags_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      cap_q   <= 1'b0;
    end else if (seq_clear_i) begin
      flags_q <= '0;
      cap_q   <= 1'b0;
    end else if (armed && (winner != '0)) begin
      flags_q <= winner;
      cap_q   <= 1'b1;
    end else begin
      cap_q   <= 1'b0;
    end
  end

  assign flags_o    = flags_q;
  assign captured_o = cap_q;

  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flags_q)); // R4
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    seq_clear_i |=> (flags_q == '0)); // R5
  AST_HOLD_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_q != '0) && !seq_clear_i) |=> $stable(flags_q)); // R7
  AST_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_i && (flags_q == '0)) |=> (flags_q == '0)); // R6
  AST_FROM_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_q != '0) && ($past(flags_q) == '0)) |-> ((flags_q & $past(fall_i)) != '0)); // R2
  AST_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_q != '0) && ($past(flags_q) == '0)) |-> ((($past(fall_i)) & (flags_q - 1'b1)) == '0)); // R8
endmodule

// File: rtl/chan_capture_arbiter.sv
module chan_capture_arbiter #(
  parameter int unsigned N_CH        = cca_pkg::CCA_CH_DEF,
  parameter int unsigned SYNC_STAGES = cca_pkg::CCA_SYNC_DEF,
  localparam int unsigned IDX_W      = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CH-1:0]  req_n_i,
  input  logic             enable_i,
  input  logic             seq_clear_i,
  output logic [N_CH-1:0]  grant_oh_o,
  output logic [IDX_W-1:0] grant_idx_o,
  output logic             captured_o
);
  function automatic logic [IDX_W-1:0] onehot_index(input logic [N_CH-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (v[i]) r = r | IDX_W'(i);
    end
    return r;
  endfunction

  logic [N_CH-1:0] fall_w;
  logic [N_CH-1:0] flags_w;

  cca_edge_sync #(.N_CH(N_CH), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_n_i (req_n_i),
    .fall_o  (fall_w)
  );

  cca_lock #(.N_CH(N_CH)) u_lock (
    .clk         (clk),
    .rst_n       (rst_n),
    .fall_i      (fall_w),
    .enable_i    (enable_i),
    .seq_clear_i (seq_clear_i),
    .flags_o     (flags_w),
    .captured_o  (captured_o)
  );

  assign grant_oh_o  = flags_w;
  assign grant_idx_o = onehot_index(flags_w);

  AST_IDX_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_oh_o == '0) ? (grant_idx_o == '0) : grant_oh_o[grant_idx_o]); // R9
  AST_CAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    captured_o |-> ((grant_oh_o != '0) && ($past(grant_oh_o) == '0))); // R10
  AST_CAP_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    captured_o |=> !captured_o); // R10
endmodule

// File: tb/tb_chan_capture_arbiter.sv
module tb_chan_capture_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_n = 8'hFF;
  logic       en = 1'b1;
  logic       clr = 1'b0;
  logic [7:0] oh;
  logic [2:0] idx;
  logic       cap;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string tag = "R1";

  // reference model state
  logic [7:0] hist[$];
  int  m_ch = -1;
  bit  m_cap = 1'b0;

  chan_capture_arbiter dut (
    .clk(clk), .rst_n(rst_n), .req_n_i(req_n), .enable_i(en),
    .seq_clear_i(clr), .grant_oh_o(oh), .grant_idx_o(idx), .captured_o(cap)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference: a channel counts as falling at edge E when it was
  // high in the sample of edge E-3 and low in the sample of edge E-2
  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{8'hFF, 8'hFF, 8'hFF};
      m_ch = -1;
      m_cap = 1'b0;
    end else begin
      logic [7:0] older, newer;
      int pick;
      older = hist[0];
      newer = hist[1];
      pick = -1;
      for (int i = N-1; i >= 0; i--) begin
        if (older[i] && !newer[i]) pick = i;
      end
      if (clr) begin
        m_ch = -1; m_cap = 1'b0;
      end else if (m_ch < 0 && en && pick >= 0) begin
        m_ch = pick; m_cap = 1'b1;
      end else begin
        m_cap = 1'b0;
      end
      void'(hist.pop_front());
      hist.push_back(req_n);
    end
  end

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic [7:0] e_oh;
      e_oh = (m_ch >= 0) ? (8'h01 << m_ch) : 8'h00;
      check("flags", {24'h0, oh}, {24'h0, e_oh});
      check("index R9", {29'h0, idx}, (m_ch >= 0) ? m_ch : 0);
      check("captured R10", {31'h0, cap}, {31'h0, m_cap});
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic release_event();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  initial begin
    hist = '{8'hFF, 8'hFF, 8'hFF};
    repeat (3) @(negedge clk);
    tag = "R1";
    check("reset flags", {24'h0, oh}, 32'h0);
    check("reset idx", {29'h0, idx}, 32'h0);
    check("reset cap", {31'h0, cap}, 32'h0);
    rst_n = 1'b1;
    idle(4);

    // R2: single capture, exact latency (model checks every cycle)
    tag = "R2";
    req_n[5] = 1'b0;
    idle(1);
    check("no early flag R2", {24'h0, oh}, 32'h0);
    idle(5);
    check("ch5 latched R2", {24'h0, oh}, 32'h20);

    // R4: other channels ignored while held
    tag = "R4";
    req_n[2] = 1'b0; idle(2); req_n[2] = 1'b1; req_n[6] = 1'b0; idle(6);
    check("still ch5 R4", {24'h0, oh}, 32'h20);
    req_n = 8'hFF;
    release_event(); idle(4);

    // R8: simultaneous falls, lowest wins
    tag = "R8";
    req_n = 8'b1011_0101;
    idle(6);
    check("lowest wins R8", {24'h0, oh}, 32'h02);
    req_n = 8'hFF; release_event(); idle(4);

    // R6 then R3: fall while disabled, then enable with line still low
    tag = "R6";
    en = 1'b0; req_n[4] = 1'b0; idle(6);
    check("disabled R6", {24'h0, oh}, 32'h0);
    tag = "R3";
    en = 1'b1; idle(6);
    check("held low R3", {24'h0, oh}, 32'h0);
    req_n[4] = 1'b1; idle(6);
    check("rise ignored R3", {24'h0, oh}, 32'h0);

    // R7: enable drop after capture
    tag = "R7";
    req_n[3] = 1'b0; idle(5); en = 1'b0; idle(4);
    check("held after en drop R7", {24'h0, oh}, 32'h08);
    en = 1'b1; req_n = 8'hFF;

    // R5: clear clears, falls under clear are forgotten
    tag = "R5";
    @(negedge clk); clr = 1'b1;
    @(negedge clk);
    check("cleared R5", {24'h0, oh}, 32'h0);
    req_n[1] = 1'b0; idle(6); clr = 1'b0; idle(6);
    check("fall under clear lost R5", {24'h0, oh}, 32'h0);
    req_n = 8'hFF; idle(4);

    // R9: index boundaries
    tag = "R9";
    req_n[7] = 1'b0; idle(6);
    check("idx 7 R9", {29'h0, idx}, 32'd7);
    req_n = 8'hFF; release_event(); idle(4);
    req_n[0] = 1'b0; idle(6);
    check("idx 0 flag R9", {24'h0, oh}, 32'h01);
    req_n = 8'hFF; release_event(); idle(4);

    // R10: back-to-back events, pulse on each
    tag = "R10";
    for (int k = 0; k < N; k++) begin
      req_n[k] = 1'b0; idle(5); req_n = 8'hFF; release_event(); idle(3);
    end
    idle(5);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule